// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block generates the word address for each beat of a four-beat burst into a synchronous memory. A load pulse captures a full start address. From then on, the block drives that address out unchanged apart from the two least significant bits. On every clock where the active-low advance input is low, those two bits step to the next beat of the burst.

A mode input picks the beat order. When it is high the order is interleaved: the start bits are XORed with the beat index. When it is low the order is linear: the beat index is added to the start bits, modulo four. The mode is a static strap and is changed only while no burst is running, and then only with a fresh load. A load always wins over an advance in the same cycle and restarts the beat count. Advancing past the fourth beat wraps the sequence back to the start address, so a long run of advances repeats the same four addresses.

Top module: `burstAddrSeq`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `burstAddr` is all zeros.
- R2: When `load` is high at a rising edge, `burstAddr` equals the `loadAddr` sampled at that edge from the end of that edge onward. This is beat 0.
- R3: When `load` is low and `advN` is high at an edge, `burstAddr` keeps its value through that edge.
- R4: With `interleave` high, beat k (k = 0..3, counting edges with `advN` low since the load) drives bits [1:0] of `burstAddr` to start[1:0] XOR k.
- R5: With `interleave` low, beat k drives bits [1:0] of `burstAddr` to (start[1:0] + k) mod 4.
- R6: Bits [ADDR_W-1:2] of `burstAddr` equal the loaded address's upper bits for the whole burst and change only on a load.
- R7: When `load` is high and `advN` is low at the same edge, the load takes effect. The advance is ignored, and the following beat is beat 1 of the new burst.
- R8: After four advances, bits [1:0] return to the start bits, and further advances repeat the same four-beat order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Captures `loadAddr` as the start of a new burst |
| loadAddr | input | ADDR_W | Start address of the burst |
| advN | input | 1 | Active-low step to the next beat |
| interleave | input | 1 | Order select: 1 = interleaved, 0 = linear (static) |
| burstAddr | output | ADDR_W | Address of the current beat |

## Verification
A wrong start register or a wrong beat counter shows up on bits [1:0] of `burstAddr` right after the first advance that follows the load. Mixing up the orders gives the same sequence for start 0 but different sequences for odd starts, so the bench uses starts 1, 2 and 3 in both modes. A counter that loses its place after the fourth beat is caught by bursts that run eight beats or more. A load that does not override an advance shows up as the wrong address one edge after the collision. Stall cycles between advances catch a counter that steps on every clock.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadEn;   // capture a new start address, clear beat count
    logic stepEn;   // move to next beat
  } seqStrobe_t;

  localparam int BEAT_W = 2;  // four beats per burst

endpackage

// File: rtl/burstSeqCtrl.sv
module burstSeqCtrl
  import burst_seq_pkg::*;
(
  input  logic       load,
  input  logic       advN,
  output seqStrobe_t strb
);

  // A load has priority; an advance only counts when no load is present
  always_comb begin
    strb.loadEn = load;
    strb.stepEn = !load && !advN;
  end

endmodule

// File: rtl/burstSeqPath.sv
module burstSeqPath
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic              interleave,
  output logic [ADDR_W-1:0] burstAddr
);

  localparam int UP_W = ADDR_W - BEAT_W;

  logic [UP_W-1:0]   upperQ;
  logic [BEAT_W-1:0] startQ;
  logic [BEAT_W-1:0] beatQ;
  logic [BEAT_W-1:0] lowLinear;
  logic [BEAT_W-1:0] lowInter;
  logic [BEAT_W-1:0] lowOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upperQ <= '0;
      startQ <= '0;
      beatQ  <= '0;
    end else if (strb.loadEn) begin
      upperQ <= loadAddr[ADDR_W-1:BEAT_W];
      startQ <= loadAddr[BEAT_W-1:0];
      beatQ  <= '0;
    end else if (strb.stepEn) begin
      beatQ  <= beatQ + 1'b1;   // natural wrap after the fourth beat
    end
  end

  // Both orders are always computed; the static mode picks one
  always_comb begin
    lowLinear = startQ + beatQ;
    lowInter  = startQ ^ beatQ;
    lowOut    = interleave ? lowInter : lowLinear;
    burstAddr = {upperQ, lowOut};
  end

  // R8: fourth advance returns the count to the first beat
  a_r8_wrap_to_start: assert property (@(posedge clk) disable iff (!rstN)
    (beatQ == 2'd3 && strb.stepEn) |=> (beatQ == 2'd0));

  // R7: a load clears the beat count even with a pending advance
  a_r7_load_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadEn |=> (beatQ == 2'd0));

endmodule

// File: rtl/burstAddrSeq.sv
module burstAddrSeq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic              advN,
  input  logic              interleave,
  output logic [ADDR_W-1:0] burstAddr
);

  seqStrobe_t strb;

  burstSeqCtrl i_ctrl (
    .load (load),
    .advN (advN),
    .strb (strb)
  );

  burstSeqPath #(.ADDR_W(ADDR_W)) i_path (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .loadAddr   (loadAddr),
    .interleave (interleave),
    .burstAddr  (burstAddr)
  );

  // R2: loaded address appears after the load edge
  a_r2_load_visible: assert property (@(posedge clk) disable iff (!rstN)
    load |=> (burstAddr == $past(loadAddr)));

  // R3: without load or advance the address holds (mode unchanged)
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!load && advN) |=>
      ((interleave != $past(interleave)) || (burstAddr == $past(burstAddr))));

  // R6: upper bits change only on a load
  a_r6_upper_steady: assert property (@(posedge clk) disable iff (!rstN)
    !load |=> (burstAddr[ADDR_W-1:BEAT_W] == $past(burstAddr[ADDR_W-1:BEAT_W])));

endmodule

// File: tb/test_burstAddrSeq.sv
`timescale 1ns/1ps
module test_burstAddrSeq;

  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          load = 1'b0;
  logic [AW-1:0] loadAddr = '0;
  logic          advN = 1'b1;
  logic          interleave = 1'b0;
  logic [AW-1:0] burstAddr;

  always #2 clk = ~clk;  // 250 MHz

  burstAddrSeq #(.ADDR_W(AW)) i_burstAddrSeq (
    .clk(clk), .rstN(rstN), .load(load), .loadAddr(loadAddr),
    .advN(advN), .interleave(interleave), .burstAddr(burstAddr)
  );

  typedef struct {
    logic [AW-1:0] exp;
    string         tag;
  } expItem_t;

  expItem_t      sbQ[$];
  int            checks = 0;
  int            errors = 0;
  bit            done = 0;

  // reference model state
  logic [AW-3:0] mUpper = '0;
  logic [1:0]    mStart = '0;
  logic [1:0]    mBeat  = '0;

  function automatic logic [AW-1:0] modelAddr();
    logic [1:0] lo;
    lo = interleave ? (mStart ^ mBeat) : (mStart + mBeat);
    return {mUpper, lo};
  endfunction

  // driver: drive at negedge, advance model, queue expectation
  task automatic step(input logic ld, input logic [AW-1:0] a,
                      input logic an, input string tag);
    load = ld; loadAddr = a; advN = an;
    if (ld) begin
      mUpper = a[AW-1:2]; mStart = a[1:0]; mBeat = 2'd0;
    end else if (!an) begin
      mBeat = mBeat + 2'd1;
    end
    sbQ.push_back('{modelAddr(), tag});
    @(negedge clk);
  endtask

  task automatic burst(input logic [AW-1:0] a, input int nAdv, input string tag);
    step(1'b1, a, 1'b1, "R2");
    for (int i = 0; i < nAdv; i++) step(1'b0, a, 1'b0, tag);
  endtask

  // monitor: compare one expectation per edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbQ.size() > 0) begin
        expItem_t it;
        it = sbQ.pop_front();
        checks++;
        if (burstAddr !== it.exp) begin
          errors++;
          $display("FAIL %s: burstAddr=%h expected=%h", it.tag, burstAddr, it.exp);
        end
      end
    end
  end

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      finishRun();
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (burstAddr !== '0) begin
      errors++;
      $display("FAIL R1: burstAddr=%h expected=%h", burstAddr, 16'h0);
    end
    rstN = 1'b1;
    step(1'b0, '0, 1'b1, "R1");

    // R4: interleaved order, odd and even starts
    interleave = 1'b1;
    burst(16'hA5C1, 3, "R4");
    burst(16'h1232, 3, "R4");
    burst(16'h7FF3, 3, "R4");
    // R5: linear order, same starts
    interleave = 1'b0;
    burst(16'hA5C1, 3, "R5");
    burst(16'h1232, 3, "R5");
    burst(16'hFFFF, 3, "R5");

    // R3: stalls inside a burst; R6 upper bits constant
    step(1'b1, 16'h3C02, 1'b1, "R2");
    step(1'b0, 16'h0000, 1'b1, "R3");
    step(1'b0, 16'hFFFF, 1'b0, "R6");
    step(1'b0, 16'h0000, 1'b1, "R3");
    step(1'b0, 16'h0000, 1'b1, "R3");
    step(1'b0, 16'h5555, 1'b0, "R6");

    // R8: wrap past four beats in both modes
    burst(16'h0041, 9, "R8");
    interleave = 1'b1;
    burst(16'h8003, 9, "R8");

    // R7: load collides with advance mid-burst
    burst(16'h2222, 2, "R4");
    step(1'b1, 16'h4441, 1'b0, "R7");
    step(1'b0, 16'h0000, 1'b0, "R7");
    step(1'b0, 16'h0000, 1'b0, "R7");
    interleave = 1'b0;
    burst(16'h9992, 1, "R5");
    step(1'b1, 16'h6663, 1'b0, "R7");
    step(1'b0, 16'h0000, 1'b0, "R7");

    step(1'b0, 16'h0000, 1'b1, "R3");
    @(negedge clk);
    done = 1;
    finishRun();
  end

endmodule